// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block sits inside a general-purpose timer and produces the one trigger line that the timer offers to slave timers and converters. A four-bit mode field picks the source of that line. The sources are the software update strobe, the counter enable, the update event, a per-event pulse from channel 1's capture/compare flag logic, one of four compare reference levels, or the encoder clock. The chosen source is registered before it leaves the block. Counter, compare channels, encoder and slave controller are outside the block and reach it only as strobes and levels.

Two further controls share the configuration register. The first is an input-conditioning switch that replaces channel 1's input with the XOR of the three input channels, which suits Hall-effect sensors. The second is a DMA source switch that makes every channel's DMA request follow either its own capture/compare event or the update event.

Configuration is written as one word when `cfg_we` is high. A sync-bypass bit removes the extra alignment stage that the counter enable otherwise carries when the trigger input gates it.

Top module: `trig_out_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, all configuration fields clear to zero, so the mode is 0000 and the XOR, DMA and bypass switches are off. `trgo`, `dma_req` and `enc_cfg_err` are low after that edge.
- R2: In mode 0000, `trgo` equals `sw_upd` one clock later. A `slv_reset` strobe from the slave controller appears on `trgo` two clocks later.
- R3: In mode 0001, the counter enable is `cen_bit` AND (`trig_in` when `gated_mode` is 1, else 1). It reaches `trgo` one clock later when `gated_mode` is 0 or the bypass bit is 1.
- R4: In mode 0001 with `gated_mode` 1 and the bypass bit 0, the counter enable reaches `trgo` two clocks later.
- R5: In mode 0010, `trgo` equals `update_evt` one clock later.
- R6: In mode 0011, every cycle with `cc1_set` high gives a high `trgo` one clock later, including back-to-back cycles.
- R7: Modes 0100, 0101, 0110 and 0111 route `ocref[0]`, `ocref[1]`, `ocref[2]` and `ocref[3]` respectively to `trgo` with one clock of latency.
- R8: In mode 1000 with `slave_mode` in {0001, 0010, 0011, 1010, 1011, 1100, 1101, 1110, 1111}, `trgo` equals `enc_clk` one clock later and `enc_cfg_err` is low.
- R9: In mode 1000 with any other `slave_mode`, `trgo` is low and `enc_cfg_err` is high one clock later. In every other mode, `enc_cfg_err` is low.
- R10: Mode codes 1001 to 1111 hold `trgo` low whatever the sources do.
- R11: With the XOR switch on, `ch1_out` is the XOR of `ch_in[2:0]`. With it off, `ch1_out` equals `ch_in[0]`. There is no clock delay.
- R12: With the DMA switch off, `dma_req[i]` equals `cc_evt[i]` one clock later. With it on, every `dma_req` bit equals `update_evt` one clock later.
- R13: Configuration inputs are captured only at an edge where `cfg_we` is high. A changed `cfg_mode` with `cfg_we` low has no effect on `trgo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer kernel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_mode | input | 4 | Trigger source mode to write |
| cfg_xor_in | input | 1 | XOR input conditioning switch to write |
| cfg_dma_upd | input | 1 | DMA source switch to write (1 = update event) |
| cfg_sync_byp | input | 1 | Sync bypass switch to write |
| slave_mode | input | 4 | Current slave controller mode code |
| sw_upd | input | 1 | Software update-generate strobe |
| slv_reset | input | 1 | Counter reset strobe issued by the slave controller |
| cen_bit | input | 1 | Counter enable control bit |
| gated_mode | input | 1 | Slave controller is in gated mode |
| trig_in | input | 1 | Trigger input level |
| update_evt | input | 1 | Update event strobe |
| cc1_set | input | 1 | Channel 1 flag-set event strobe |
| ocref | input | 4 | Compare reference levels of channels 1 to 4 |
| enc_clk | input | 1 | Encoder clock |
| ch_in | input | 3 | Raw input channels 1 to 3 |
| cc_evt | input | 4 | Capture/compare event strobes per channel |
| ch1_out | output | 1 | Conditioned channel 1 input |
| dma_req | output | 4 | Capture/compare DMA requests per channel |
| trgo | output | 1 | Registered trigger output |
| enc_cfg_err | output | 1 | Encoder clock selected with an illegal slave mode |

## Verification
On every cycle the assertions check the update, software-strobe and flag-pulse routes, the low output for reserved codes, the illegal encoder pairing flag, the XOR conditioning and the DMA source choice. Only the bench scenarios can show the two-clock alignment of a gated counter enable and how the bypass removes it. The same is true of the extra stage on a slave-issued reset, the mapping of each compare reference to its own code, and whether a configuration change without the write strobe is ignored. Those need chosen sequences of writes and strobes.

// File: rtl/trgo_pkg.sv
// Package: shared mode codes, configuration word and helpers for the
// master trigger output selector. Assumes a 4-bit mode field.
package trgo_pkg;

    localparam int MODE_W = 4;
    localparam int SMODE_W = 4;

    // Mode codes; the numeric values are fixed by the timer's programming model.
    typedef enum logic [MODE_W-1:0] {
        TM_SWUPD    = 4'd0,
        TM_CNTEN    = 4'd1,
        TM_UPDATE   = 4'd2,
        TM_CC1PULSE = 4'd3,
        TM_OC_BASE  = 4'd4,
        TM_ENCCLK   = 4'd8
    } trgo_mode_e;

    // Configuration word held by the block.
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              xor_in;
        logic              dma_upd;
        logic              sync_byp;
    } trgo_cfg_t;

    // True when the slave-mode code permits the encoder clock as trigger source.
    function automatic logic enc_slave_ok(input logic [SMODE_W-1:0] sm);
        return (sm == 4'd1) || (sm == 4'd2) || (sm == 4'd3) || (sm >= 4'd10);
    endfunction

endpackage

// File: rtl/trgo_cfg_regs.sv
// Module: configuration register of the trigger selector.
// Captures the whole configuration word when the write strobe is high and
// clears it to zero on a synchronous active-low reset.
module trgo_cfg_regs
    import trgo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  trgo_cfg_t wr_cfg,
    output trgo_cfg_t cfg_q
);

    // Hold the configuration; load only on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= wr_cfg;
        end
    end

endmodule

// File: rtl/trgo_align.sv
// Module: delay alignment for the counter-enable and slave-reset sources.
// Forms the counter enable (control bit gated by the trigger input in gated
// mode) and delays it one extra stage when the trigger input gates it,
// unless the sync bypass is set. A slave-issued reset is always delayed one
// stage. Assumes the strobes are synchronous to clk.
module trgo_align (
    input  logic clk,
    input  logic rst_n,
    input  logic cen_bit,
    input  logic gated_mode,
    input  logic trig_in,
    input  logic sync_byp,
    input  logic slv_reset,
    output logic en_src,
    output logic rst_src
);

    logic cnt_en;
    logic cnt_en_q;
    logic slv_reset_q;

    // Counter enable as the counter sees it.
    always_comb begin
        cnt_en = cen_bit & (gated_mode ? trig_in : 1'b1);
    end

    // Alignment stages for the gated enable and the slave reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_en_q    <= 1'b0;
            slv_reset_q <= 1'b0;
        end else begin
            cnt_en_q    <= cnt_en;
            slv_reset_q <= slv_reset;
        end
    end

    // Pick the direct or the delayed enable.
    always_comb begin
        en_src  = (gated_mode && !sync_byp) ? cnt_en_q : cnt_en;
        rst_src = slv_reset_q;
    end

endmodule

// File: rtl/trgo_src_mux.sv
// Module: trigger source multiplexer and output register.
// Selects one source by mode code, registers it onto trgo and flags an
// encoder clock selection paired with an illegal slave-mode code.
// Reserved codes drive the output low. Assumes NUM_OC <= 4.
module trgo_src_mux
    import trgo_pkg::*;
#(
    parameter int NUM_OC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode,
    input  logic [SMODE_W-1:0] slave_mode,
    input  logic               sw_upd,
    input  logic               rst_src,
    input  logic               en_src,
    input  logic               update_evt,
    input  logic               cc1_set,
    input  logic [NUM_OC-1:0]  ocref,
    input  logic               enc_clk,
    output logic               trgo,
    output logic               enc_cfg_err
);

    localparam int OC_FIRST = int'(TM_OC_BASE);

    logic oc_sel;
    logic enc_ok;
    logic sel;
    logic err_nxt;

    // Compare reference pick; codes outside the compare range give 0.
    always_comb begin
        oc_sel = 1'b0;
        for (int i = 0; i < NUM_OC; i++) begin
            if (mode == MODE_W'(OC_FIRST + i)) begin
                oc_sel = ocref[i];
            end
        end
    end

    // Legality of the encoder clock for the current slave mode.
    always_comb begin
        enc_ok = enc_slave_ok(slave_mode);
    end

    // Main source selection by mode code.
    always_comb begin
        sel     = 1'b0;
        err_nxt = 1'b0;
        case (mode)
            TM_SWUPD:    sel = sw_upd | rst_src;
            TM_CNTEN:    sel = en_src;
            TM_UPDATE:   sel = update_evt;
            TM_CC1PULSE: sel = cc1_set;
            TM_ENCCLK: begin
                sel     = enc_ok & enc_clk;
                err_nxt = !enc_ok;
            end
            default:     sel = oc_sel;
        endcase
    end

    // Output register for the trigger and the configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trgo        <= 1'b0;
            enc_cfg_err <= 1'b0;
        end else begin
            trgo        <= sel;
            enc_cfg_err <= err_nxt;
        end
    end

endmodule

// File: rtl/trgo_in_cond.sv
// Module: input conditioning and DMA request source.
// Drives channel 1 with its own input or the XOR of all input channels,
// and registers one DMA request per channel from either its channel event
// or the update event. Assumes NUM_IN >= 1.
module trgo_in_cond #(
    parameter int NUM_IN = 3,
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xor_in,
    input  logic              dma_upd,
    input  logic [NUM_IN-1:0] ch_in,
    input  logic [NUM_CH-1:0] cc_evt,
    input  logic              update_evt,
    output logic              ch1_out,
    output logic [NUM_CH-1:0] dma_req
);

    // Channel 1 conditioning, combinational.
    always_comb begin
        ch1_out = xor_in ? (^ch_in) : ch_in[0];
    end

    // One registered DMA request per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dma
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dma_req[c] <= 1'b0;
            end else begin
                dma_req[c] <= dma_upd ? update_evt : cc_evt[c];
            end
        end
    end

endmodule

// File: rtl/trig_out_sel.sv
// Module: master trigger output selector (top).
// Ties the configuration register, enable/reset alignment, source
// multiplexer and input conditioning together. All outputs are reset by a
// synchronous active-low reset; trgo carries one clock of latency.
module trig_out_sel
    import trgo_pkg::*;
#(
    parameter int NUM_OC = 4,
    parameter int NUM_IN = 3,
    parameter int NUM_CH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic               cfg_xor_in,
    input  logic               cfg_dma_upd,
    input  logic               cfg_sync_byp,
    input  logic [SMODE_W-1:0] slave_mode,
    input  logic               sw_upd,
    input  logic               slv_reset,
    input  logic               cen_bit,
    input  logic               gated_mode,
    input  logic               trig_in,
    input  logic               update_evt,
    input  logic               cc1_set,
    input  logic [NUM_OC-1:0]  ocref,
    input  logic               enc_clk,
    input  logic [NUM_IN-1:0]  ch_in,
    input  logic [NUM_CH-1:0]  cc_evt,
    output logic               ch1_out,
    output logic [NUM_CH-1:0]  dma_req,
    output logic               trgo,
    output logic               enc_cfg_err
);

    trgo_cfg_t         wr_cfg;
    trgo_cfg_t         cfg_q;
    logic [MODE_W-1:0] mode_q;
    logic              xor_q;
    logic              dma_q;
    logic              en_src;
    logic              rst_src;

    // Pack the write port into a configuration word.
    always_comb begin
        wr_cfg.mode     = cfg_mode;
        wr_cfg.xor_in   = cfg_xor_in;
        wr_cfg.dma_upd  = cfg_dma_upd;
        wr_cfg.sync_byp = cfg_sync_byp;
    end

    // Flat views of the held fields.
    always_comb begin
        mode_q = cfg_q.mode;
        xor_q  = cfg_q.xor_in;
        dma_q  = cfg_q.dma_upd;
    end

    trgo_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q)
    );

    trgo_align u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .cen_bit    (cen_bit),
        .gated_mode (gated_mode),
        .trig_in    (trig_in),
        .sync_byp   (cfg_q.sync_byp),
        .slv_reset  (slv_reset),
        .en_src     (en_src),
        .rst_src    (rst_src)
    );

    trgo_src_mux #(.NUM_OC(NUM_OC)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .slave_mode  (slave_mode),
        .sw_upd      (sw_upd),
        .rst_src     (rst_src),
        .en_src      (en_src),
        .update_evt  (update_evt),
        .cc1_set     (cc1_set),
        .ocref       (ocref),
        .enc_clk     (enc_clk),
        .trgo        (trgo),
        .enc_cfg_err (enc_cfg_err)
    );

    trgo_in_cond #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .xor_in     (xor_q),
        .dma_upd    (dma_q),
        .ch_in      (ch_in),
        .cc_evt     (cc_evt),
        .update_evt (update_evt),
        .ch1_out    (ch1_out),
        .dma_req    (dma_req)
    );

endmodule

// File: rtl/trgo_chk.sv
// Module: assertion checker for the trigger selector, bound to the top.
// Observes ports and the held configuration fields only.
module trgo_chk
    import trgo_pkg::*;
#(
    parameter int NUM_IN = 3,
    parameter int NUM_CH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [MODE_W-1:0]  mode_q,
    input logic               xor_q,
    input logic               dma_q,
    input logic [SMODE_W-1:0] slave_mode,
    input logic               sw_upd,
    input logic               update_evt,
    input logic               cc1_set,
    input logic [NUM_IN-1:0]  ch_in,
    input logic               ch1_out,
    input logic [NUM_CH-1:0]  dma_req,
    input logic               trgo,
    input logic               enc_cfg_err
);

    // R2
    swupd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_SWUPD && sw_upd) |=> trgo);

    // R5
    update_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_UPDATE) |=> (trgo == $past(update_evt)));

    // R6
    cc1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_CC1PULSE && cc1_set) |=> trgo);

    // R9
    enc_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TM_ENCCLK && !enc_slave_ok(slave_mode)) |=> (enc_cfg_err && !trgo));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != TM_ENCCLK) |=> !enc_cfg_err);

    // R10
    reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q > TM_ENCCLK) |=> !trgo);

    // R11
    xor_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xor_q |-> (ch1_out == ^ch_in));

    // R12
    dma_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_q |=> (dma_req == {NUM_CH{$past(update_evt)}}));

endmodule

bind trig_out_sel trgo_chk #(.NUM_IN(NUM_IN), .NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_q      (mode_q),
    .xor_q       (xor_q),
    .dma_q       (dma_q),
    .slave_mode  (slave_mode),
    .sw_upd      (sw_upd),
    .update_evt  (update_evt),
    .cc1_set     (cc1_set),
    .ch_in       (ch_in),
    .ch1_out     (ch1_out),
    .dma_req     (dma_req),
    .trgo        (trgo),
    .enc_cfg_err (enc_cfg_err)
);

// File: tb/trig_out_sel_test.sv
// Directed bench for the trigger selector: one task per scenario.
module trig_out_sel_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [3:0] cfg_mode;
    logic       cfg_xor_in;
    logic       cfg_dma_upd;
    logic       cfg_sync_byp;
    logic [3:0] slave_mode;
    logic       sw_upd;
    logic       slv_reset;
    logic       cen_bit;
    logic       gated_mode;
    logic       trig_in;
    logic       update_evt;
    logic       cc1_set;
    logic [3:0] ocref;
    logic       enc_clk;
    logic [2:0] ch_in;
    logic [3:0] cc_evt;
    logic       ch1_out;
    logic [3:0] dma_req;
    logic       trgo;
    logic       enc_cfg_err;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trig_out_sel uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_xor_in(cfg_xor_in), .cfg_dma_upd(cfg_dma_upd),
        .cfg_sync_byp(cfg_sync_byp), .slave_mode(slave_mode),
        .sw_upd(sw_upd), .slv_reset(slv_reset), .cen_bit(cen_bit),
        .gated_mode(gated_mode), .trig_in(trig_in), .update_evt(update_evt),
        .cc1_set(cc1_set), .ocref(ocref), .enc_clk(enc_clk), .ch_in(ch_in),
        .cc_evt(cc_evt), .ch1_out(ch1_out), .dma_req(dma_req), .trgo(trgo),
        .enc_cfg_err(enc_cfg_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        sw_upd = 0; slv_reset = 0; cen_bit = 0; gated_mode = 0; trig_in = 0;
        update_evt = 0; cc1_set = 0; ocref = 0; enc_clk = 0; cc_evt = 0;
        slave_mode = 0;
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic x, input logic d, input logic b);
        cfg_mode = m; cfg_xor_in = x; cfg_dma_upd = d; cfg_sync_byp = b;
        cfg_we = 1;
        tick();
        cfg_we = 0;
        tick();
    endtask

    task automatic t_reset();
        ch_in = 3'b010;
        #1;
        chk("R1 trgo", {7'd0, trgo}, 8'd0);
        chk("R1 dma", {4'd0, dma_req}, 8'd0);
        chk("R1 err", {7'd0, enc_cfg_err}, 8'd0);
        chk("R1 xor off", {7'd0, ch1_out}, 8'd0);
        sw_upd = 1;
        tick();
        chk("R1 mode0 after reset", {7'd0, trgo}, 8'd1);
        sw_upd = 0;
        tick();
    endtask

    task automatic t_swupd();
        set_cfg(4'd0, 0, 0, 0);
        sw_upd = 1; tick();
        chk("R2 sw strobe", {7'd0, trgo}, 8'd1);
        sw_upd = 0; tick();
        chk("R2 sw idle", {7'd0, trgo}, 8'd0);
        slv_reset = 1; tick();
        chk("R2 slave reset first clock", {7'd0, trgo}, 8'd0);
        slv_reset = 0; tick();
        chk("R2 slave reset second clock", {7'd0, trgo}, 8'd1);
        tick();
        chk("R2 slave reset done", {7'd0, trgo}, 8'd0);
    endtask

    task automatic t_cnten();
        set_cfg(4'd1, 0, 0, 0);
        cen_bit = 1; tick();
        chk("R3 ungated enable", {7'd0, trgo}, 8'd1);
        cen_bit = 0; tick();
        chk("R3 enable off", {7'd0, trgo}, 8'd0);
        gated_mode = 1; trig_in = 1; cen_bit = 1; tick();
        chk("R4 gated first clock", {7'd0, trgo}, 8'd0);
        tick();
        chk("R4 gated second clock", {7'd0, trgo}, 8'd1);
        trig_in = 0; tick();
        chk("R4 gated fall lag", {7'd0, trgo}, 8'd1);
        tick();
        chk("R4 gated fall", {7'd0, trgo}, 8'd0);
        set_cfg(4'd1, 0, 0, 1);
        trig_in = 1; tick();
        chk("R3 bypass one clock", {7'd0, trgo}, 8'd1);
        cen_bit = 0; tick();
        chk("R3 gated by control bit", {7'd0, trgo}, 8'd0);
        quiet();
    endtask

    task automatic t_update();
        set_cfg(4'd2, 0, 0, 0);
        update_evt = 1; tick();
        chk("R5 update high", {7'd0, trgo}, 8'd1);
        update_evt = 0; sw_upd = 1; tick();
        chk("R5 other source ignored", {7'd0, trgo}, 8'd0);
        quiet();
    endtask

    task automatic t_cc1();
        set_cfg(4'd3, 0, 0, 0);
        cc1_set = 1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 back-to-back pulse", {7'd0, trgo}, 8'd1);
        end
        cc1_set = 0; tick();
        chk("R6 pulse ends", {7'd0, trgo}, 8'd0);
    endtask

    task automatic t_ocref();
        for (int i = 0; i < 4; i++) begin
            set_cfg(4'(4 + i), 0, 0, 0);
            ocref = 4'(1 << i); tick();
            chk("R7 own ref high", {7'd0, trgo}, 8'd1);
            ocref = ~4'(1 << i); tick();
            chk("R7 other refs ignored", {7'd0, trgo}, 8'd0);
        end
        quiet();
    endtask

    task automatic t_enc();
        set_cfg(4'd8, 0, 0, 0);
        slave_mode = 4'b0001; enc_clk = 1; tick();
        chk("R8 legal enc high", {7'd0, trgo}, 8'd1);
        chk("R8 no error", {7'd0, enc_cfg_err}, 8'd0);
        enc_clk = 0; tick();
        chk("R8 legal enc low", {7'd0, trgo}, 8'd0);
        slave_mode = 4'b1010; enc_clk = 1; tick();
        chk("R8 code 1010 legal", {7'd0, trgo}, 8'd1);
        slave_mode = 4'b0100; tick();
        chk("R9 illegal trgo", {7'd0, trgo}, 8'd0);
        chk("R9 illegal err", {7'd0, enc_cfg_err}, 8'd1);
        slave_mode = 4'b0000; tick();
        chk("R9 code 0000 illegal", {7'd0, enc_cfg_err}, 8'd1);
        set_cfg(4'd2, 0, 0, 0);
        chk("R9 err clears outside enc mode", {7'd0, enc_cfg_err}, 8'd0);
        quiet();
    endtask

    task automatic t_reserved();
        for (int m = 9; m < 16; m++) begin
            set_cfg(4'(m), 0, 0, 0);
            sw_upd = 1; cen_bit = 1; update_evt = 1; cc1_set = 1;
            ocref = 4'hF; enc_clk = 1; slave_mode = 4'b0001;
            tick();
            chk("R10 reserved low", {7'd0, trgo}, 8'd0);
            quiet();
        end
    endtask

    task automatic t_xor();
        set_cfg(4'd0, 0, 0, 0);
        for (int v = 0; v < 8; v++) begin
            ch_in = 3'(v); #1;
            chk("R11 direct", {7'd0, ch1_out}, {7'd0, ch_in[0]});
        end
        set_cfg(4'd0, 1, 0, 0);
        for (int v = 0; v < 8; v++) begin
            ch_in = 3'(v); #1;
            chk("R11 xor", {7'd0, ch1_out}, {7'd0, ch_in[0] ^ ch_in[1] ^ ch_in[2]});
        end
    endtask

    task automatic t_dma();
        set_cfg(4'd0, 0, 0, 0);
        cc_evt = 4'b0101; update_evt = 1; tick();
        chk("R12 per-channel", {4'd0, dma_req}, 8'h05);
        set_cfg(4'd0, 0, 1, 0);
        chk("R12 update source", {4'd0, dma_req}, 8'h0F);
        update_evt = 0; tick();
        chk("R12 update idle", {4'd0, dma_req}, 8'h00);
        quiet();
    endtask

    task automatic t_cfg_hold();
        set_cfg(4'd2, 0, 0, 0);
        cfg_mode = 4'd9; cfg_we = 0; update_evt = 1; tick();
        chk("R13 write without strobe ignored", {7'd0, trgo}, 8'd1);
        tick();
        chk("R13 mode still update", {7'd0, trgo}, 8'd1);
        quiet();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_we = 0; cfg_mode = 0; cfg_xor_in = 0;
        cfg_dma_upd = 0; cfg_sync_byp = 0; ch_in = 0;
        quiet();
        @(negedge clk);
        cfg_we = 1; cfg_mode = 4'd5; cfg_xor_in = 1;
        tick(); tick();
        cfg_we = 0;
        rst_n = 1;
        t_reset();
        t_swupd();
        t_cnten();
        t_update();
        t_cc1();
        t_ocref();
        t_enc();
        t_reserved();
        t_xor();
        t_dma();
        t_cfg_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule